// File: doc/BRIEF.md
# LED Matrix Row Scanner

The block refreshes one row of a 16-row LED matrix each time a refresh tick arrives. It reads 32 bytes of pixel data for the current row from a byte-wide frame memory with one cycle of read latency. Each byte passes through a three-stage mask: a twinkle pattern is ANDed in, an inversion pattern is XORed in, and a force-on pattern is ORed in. The result is shifted out over a serial clock and data pair into a chain of external shift registers.

The row data for a given column window is not contiguous in memory. The 32 bytes of a row come as 16 pairs of adjacent bytes. The first pair starts at the window start plus twice the row number, and each later pair starts 32 bytes after the previous one. Once the last bit has been sent, the block blanks the display and drives the row number onto the decoder lines. It then pulses the latch strobe, releases the blank, and moves on to the next row, wrapping after the last one.

The window start, the inversion and force-on patterns and the twinkle enable are sampled when a tick is accepted. They therefore hold for a whole row. Pulse-width dimming of the display and loading of the frame memory are handled elsewhere.

Top module: `led_row_scanner`

## Requirements
- R1: An accepted tick starts exactly 32 single-cycle reads. The addresses are S+2r+32p+b for pair p = 0..15 and byte b = 0,1, issued in that order, where S is the sampled window start and r is the current row. Addresses wrap modulo 2^ADDR_W.
- R2: Each shifted byte equals ((D AND T) XOR I) OR F. D is the memory byte, T is the twinkle mask, and I and F are the inversion and force-on patterns sampled at the accepted tick.
- R3: With twinkle off, T is 0xFF. With twinkle on, each pair step decrements a step counter before the pair is read. When the counter reaches zero it reloads to 31 and the pattern rotates left by one bit. T is the pattern after that update. After reset the pattern is 0xAA and the counter is 31, and neither changes while twinkle is off.
- R4: Serial output uses mode 0 with MSB first. sclk idles low. sdo is set while sclk is low and does not change while sclk is high. Each half bit lasts HALF_BIT clock cycles.
- R5: After the last bit of a row, blank rises and row_sel takes the row number (bit 0 is the row LSB) on the same edge. strobe is high for the following cycle only. strobe and blank fall together.
- R6: The row number advances by one after each refresh and wraps from 15 to 0.
- R7: A tick that arrives while a row refresh is in progress is ignored. It causes no reads and no output bytes.
- R8: After reset, blank is 1, and strobe, sclk, mem_rd and row_sel are all 0.
- R9: Read data is taken from mem_rdata one cycle after mem_rd is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Refresh request, one cycle |
| win_start | input | ADDR_W | Start address of the displayed window |
| invert_mask | input | DATA_W | XOR pattern applied to every byte |
| force_mask | input | DATA_W | OR pattern applied to every byte |
| twinkle_en | input | 1 | Enables the rotating twinkle AND mask |
| mem_addr | output | ADDR_W | Frame memory read address |
| mem_rd | output | 1 | Frame memory read strobe |
| mem_rdata | input | DATA_W | Frame memory read data, one cycle after mem_rd |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data, MSB first |
| strobe | output | 1 | Latch pulse for the shift register chain |
| row_sel | output | ROW_W | Row number for the row decoder |
| blank | output | 1 | Display blanking, high turns the display off |

## Verification
The bench checks every read address against the strided sequence and sets one window start so that the addresses run past the top of memory. A design with a wrong stride or wrong wrap would therefore show up as mismatched bytes or addresses. Twinkle stays on across two rows so that the 31-step rotation lands partway through a row. An off-by-one counter would shift which pair gets 0x55 instead of 0xAA. A second tick is fired in the middle of a refresh. A scanner that restarted or queued it would issue extra reads. The bench also runs more than 16 refreshes and checks the row number and blank at each strobe, which exposes a missing wrap or a strobe outside the blanked window.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_WAIT,
    S_SHIFT,
    S_LATCH,
    S_STRB
  } scan_state_e;
endpackage

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int ADDR_W = 12,
  parameter int ROW_W  = 4,
  parameter int STRIDE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic [ADDR_W-1:0] base,
  input  logic [ROW_W-1:0]  row,
  input  logic              adv,
  input  logic              pair_end,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] JUMP = ADDR_W'(STRIDE - 1);
  localparam logic [ADDR_W-1:0] ROW_OFS_W = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (init) begin
      addr <= base + (ADDR_W'(row) << 1);
    end else if (adv) begin
      addr <= addr + (pair_end ? JUMP : ROW_OFS_W);
    end
  end
endmodule

// File: rtl/twinkle_mask_gen.sv
module twinkle_mask_gen #(
  parameter int DATA_W = 8,
  parameter int STEPS  = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              step,
  output logic [DATA_W-1:0] mask
);
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [DATA_W-1:0] SEED = {(DATA_W/2){2'b10}};

  logic [DATA_W-1:0] pat;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pat <= SEED;
      cnt <= CW'(STEPS);
    end else if (en && step) begin
      if (cnt == CW'(1)) begin
        cnt <= CW'(STEPS);
        pat <= {pat[DATA_W-2:0], pat[DATA_W-1]};
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  assign mask = en ? pat : '1;
endmodule

// File: rtl/serial_byte_tx.sv
module serial_byte_tx #(
  parameter int DATA_W   = 8,
  parameter int HALF_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              sclk,
  output logic              sdo,
  output logic              done
);
  localparam int DW = $clog2(HALF_BIT + 1);
  localparam int BW = $clog2(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [DW-1:0]     div;
  logic [BW-1:0]     bitn;
  logic              active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      div    <= '0;
      bitn   <= '0;
      active <= 1'b0;
      sclk   <= 1'b0;
      sdo    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sh     <= din;
        sdo    <= din[DATA_W-1];
        sclk   <= 1'b0;
        div    <= '0;
        bitn   <= '0;
        active <= 1'b1;
      end else if (active) begin
        if (div == DW'(HALF_BIT - 1)) begin
          div <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
          end else begin
            sclk <= 1'b0;
            if (bitn == BW'(DATA_W - 1)) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bitn <= bitn + BW'(1);
              sh   <= sh << 1;
              sdo  <= sh[DATA_W-2];
            end
          end
        end else begin
          div <= div + DW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/led_row_scanner.sv
module led_row_scanner
  import scan_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int ROWS      = 16,
  parameter int PAIRS     = 16,
  parameter int STRIDE    = 32,
  parameter int HALF_BIT  = 2,
  parameter int TWK_STEPS = 31,
  localparam int ROW_W    = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] win_start,
  input  logic [DATA_W-1:0] invert_mask,
  input  logic [DATA_W-1:0] force_mask,
  input  logic              twinkle_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              sclk,
  output logic              sdo,
  output logic              strobe,
  output logic [ROW_W-1:0]  row_sel,
  output logic              blank
);
  localparam int BYTES  = 2 * PAIRS;
  localparam int BCNT_W = $clog2(BYTES);

  scan_state_e       state;
  logic [BCNT_W-1:0] bcnt;
  logic [ROW_W-1:0]  row;
  logic [DATA_W-1:0] inv_q, frc_q;
  logic              twk_q;
  logic [DATA_W-1:0] twk_mask, byte_out;
  logic              tx_done, start_scan, in_wait, pair_step;

  assign start_scan = (state == S_IDLE) && tick;
  assign in_wait    = (state == S_WAIT);
  assign pair_step  = (state == S_RD) && !bcnt[0];
  assign mem_rd     = (state == S_RD);
  assign byte_out   = ((mem_rdata & twk_mask) ^ inv_q) | frc_q;

  scan_addr_gen #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .STRIDE(STRIDE)) u_addr (
    .clk(clk), .rst(rst), .init(start_scan), .base(win_start), .row(row),
    .adv(in_wait), .pair_end(bcnt[0]), .addr(mem_addr)
  );

  twinkle_mask_gen #(.DATA_W(DATA_W), .STEPS(TWK_STEPS)) u_twk (
    .clk(clk), .rst(rst), .en(twk_q), .step(pair_step), .mask(twk_mask)
  );

  serial_byte_tx #(.DATA_W(DATA_W), .HALF_BIT(HALF_BIT)) u_tx (
    .clk(clk), .rst(rst), .load(in_wait), .din(byte_out),
    .sclk(sclk), .sdo(sdo), .done(tx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      bcnt    <= '0;
      row     <= '0;
      inv_q   <= '0;
      frc_q   <= '0;
      twk_q   <= 1'b0;
      strobe  <= 1'b0;
      row_sel <= '0;
      blank   <= 1'b1;
    end else begin
      unique case (state)
        S_IDLE: if (tick) begin
          inv_q <= invert_mask;
          frc_q <= force_mask;
          twk_q <= twinkle_en;
          bcnt  <= '0;
          state <= S_RD;
        end
        S_RD:    state <= S_WAIT;
        S_WAIT:  state <= S_SHIFT;
        S_SHIFT: if (tx_done) begin
          if (bcnt == BCNT_W'(BYTES - 1)) begin
            blank   <= 1'b1;
            row_sel <= row;
            state   <= S_LATCH;
          end else begin
            bcnt  <= bcnt + BCNT_W'(1);
            state <= S_RD;
          end
        end
        S_LATCH: begin
          strobe <= 1'b1;
          state  <= S_STRB;
        end
        S_STRB: begin
          strobe <= 1'b0;
          blank  <= 1'b0;
          row    <= (row == ROW_W'(ROWS - 1)) ? '0 : row + ROW_W'(1);
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_rd,
  input logic             sclk,
  input logic             sdo,
  input logic             strobe,
  input logic             blank,
  input logic [ROW_W-1:0] row_sel
);
  // R5: the latch pulse only occurs while the display is blanked
  a_r5_strobe_in_blank: assert property (@(posedge clk) disable iff (rst)
    strobe |-> blank);
  // R5: the blank is released on the same edge as the strobe falls
  a_r5_release_together: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe) |-> $fell(blank));
  // R4: data only changes while the serial clock is low
  a_r4_sdo_stable_high: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sdo));
  // R4: the serial clock is at its idle level whenever memory is read
  a_r4_idle_low_on_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !sclk);
  // R9: each read is a single cycle followed by a data cycle
  a_r9_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
  // R6: the row lines only move while the display is blanked
  a_r6_row_moves_blanked: assert property (@(posedge clk) disable iff (rst)
    !$stable(row_sel) |-> blank);
endmodule

bind led_row_scanner scan_checker #(.ROW_W(ROW_W)) u_scan_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .sclk(sclk), .sdo(sdo),
  .strobe(strobe), .blank(blank), .row_sel(row_sel)
);

// File: tb/tb_led_row_scanner.sv
module tb_led_row_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, twinkle_en = 1'b0;
  logic [ADDR_W-1:0] win_start = '0, mem_addr;
  logic [7:0] invert_mask = '0, force_mask = '0, mem_rdata = '0;
  logic mem_rd, sclk, sdo, strobe, blank;
  logic [3:0] row_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_row_scanner dut (
    .clk(clk), .rst(rst), .tick(tick), .win_start(win_start),
    .invert_mask(invert_mask), .force_mask(force_mask), .twinkle_en(twinkle_en),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .sclk(sclk), .sdo(sdo), .strobe(strobe), .row_sel(row_sel), .blank(blank)
  );

  logic [7:0] mem [MEMSZ];
  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int checks = 0, errors = 0, rd_total = 0, scans = 0;
  bit finished = 1'b0;
  logic [7:0]        q_byte[$];
  logic [ADDR_W-1:0] q_addr[$];
  logic [3:0]        q_row[$];

  int m_row = 0, m_tcnt = 31;
  logic [7:0] m_tpat = 8'hAA;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: read addresses (R1)
  always @(posedge clk) if (!rst && mem_rd) begin
    rd_total++;
    if (q_addr.size() == 0) chk(1'b0, "R7 unexpected read", int'(mem_addr), -1);
    else begin
      automatic logic [ADDR_W-1:0] e = q_addr.pop_front();
      chk(mem_addr == e, "R1 read address", int'(mem_addr), int'(e));
    end
  end

  // monitor: serial bytes (R2 R3 R4)
  logic [7:0] shreg = '0;
  int nbits = 0;
  always @(posedge sclk) begin
    shreg = {shreg[6:0], sdo};
    nbits++;
    if (nbits == 8) begin
      nbits = 0;
      if (q_byte.size() == 0) chk(1'b0, "R7 unexpected byte", int'(shreg), -1);
      else begin
        automatic logic [7:0] e = q_byte.pop_front();
        chk(shreg == e, "R2/R3/R4 shifted byte", int'(shreg), int'(e));
      end
    end
  end

  // monitor: latch (R5 R6)
  always @(posedge strobe) begin
    #1;
    if (q_row.size() == 0) chk(1'b0, "R7 unexpected strobe", int'(row_sel), -1);
    else begin
      automatic logic [3:0] e = q_row.pop_front();
      chk(row_sel == e, "R6 row number at strobe", int'(row_sel), int'(e));
      chk(blank == 1'b1, "R5 blank during strobe", int'(blank), 1);
    end
  end

  task automatic run_scan(input logic [ADDR_W-1:0] s, input logic [7:0] inv,
                          input logic [7:0] frc, input bit twk, input bit extra);
    for (int p = 0; p < 16; p++) begin
      logic [7:0] m;
      if (twk) begin
        m_tcnt--;
        if (m_tcnt == 0) begin
          m_tcnt = 31;
          m_tpat = {m_tpat[6:0], m_tpat[7]};
        end
      end
      m = twk ? m_tpat : 8'hFF;
      for (int b = 0; b < 2; b++) begin
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(int'(s) + 2*m_row + 32*p + b);
        q_addr.push_back(a);
        q_byte.push_back(((mem[a] & m) ^ inv) | frc);
      end
    end
    q_row.push_back(4'(m_row));
    @(negedge clk);
    win_start = s; invert_mask = inv; force_mask = frc; twinkle_en = twk; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    // change inputs mid-scan: sampled values must be used (R2)
    win_start = ~s; invert_mask = ~inv; force_mask = 8'h00; twinkle_en = 1'b0;
    if (extra) begin
      repeat (200) @(negedge clk);
      tick = 1'b1;           // R7: must be ignored
      @(negedge clk);
      tick = 1'b0;
    end
    @(negedge blank);
    #1;
    chk(strobe == 1'b0, "R5 strobe low when blank releases", int'(strobe), 0);
    m_row = (m_row + 1) % 16;
    scans++;
    repeat (60) @(negedge clk);
    chk(q_byte.size() == 0 && q_addr.size() == 0, "R7 scan complete, no extra work",
        q_byte.size() + q_addr.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'((i * 29) ^ (i >> 4) ^ 8'h5C);
    repeat (3) @(negedge clk);
    chk(blank == 1'b1 && strobe == 1'b0 && sclk == 1'b0 && mem_rd == 1'b0 && row_sel == 4'd0,
        "R8 reset state", {blank, strobe, sclk, mem_rd, row_sel}, 8'h80);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(mem_rd == 1'b0 && blank == 1'b1, "R8 idle before first tick",
        {mem_rd, blank}, 1);
    run_scan(12'h000, 8'h00, 8'h00, 1'b0, 1'b0);     // R1 R2 plain
    run_scan(12'h010, 8'hFF, 8'h00, 1'b0, 1'b0);     // R2 invert
    run_scan(12'h123, 8'h00, 8'h0F, 1'b1, 1'b0);     // R2 force, R3 twinkle
    run_scan(12'h040, 8'h3C, 8'h00, 1'b1, 1'b0);     // R3 rotation mid-row
    run_scan(12'hFF8, 8'h00, 8'h00, 1'b0, 1'b0);     // R1 address wrap
    run_scan(12'h200, 8'h00, 8'h00, 1'b0, 1'b1);     // R7 ignored tick
    for (int k = 0; k < 12; k++)                     // R6 wrap 15 -> 0
      run_scan(ADDR_W'(k * 5), 8'(k), 8'h00, k[0], 1'b0);
    chk(rd_total == 32 * scans, "R1/R7 total reads", rd_total, 32 * scans);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule